// File: doc/BRIEF.md
# ARINC 429 Word Acceptance Filter and Receive Buffer

This block sits behind a serial ARINC 429 line decoder. Each time the decoder finishes a 32-bit word it raises a one-cycle end-of-word strobe. The block then decides in that same clock whether the word is worth keeping. It applies three tests: a parallel compare of the word's 8-bit label against a 16-entry label table, an optional check of word bits 9 and 10 against configured values, and a pass/fail combination of the two. Before the word is stored, optional parity handling rewrites its top bit.

Accepted words enter a four-deep first-in first-out buffer. The host drains the buffer one word per read strobe. When the buffer is full and a new word arrives, the new word replaces the most recently stored entry. The block keeps registered empty and full flags and an interrupt flag. The interrupt flag follows either "not empty" or "full", chosen by a configuration bit.

The host loads the label table through a write port. It loads an 8-bit configuration word through a second write port. A configuration write, a held channel-reset bit, a master-clear pulse or the system reset empties the buffer. Only the system reset clears the configuration and the label table.

Top module: `arinc_word_filter_buf`

## Requirements
- R1: With configuration bit 0 (label enable) set, a word is stored only if its bits [7:0] equal at least one of the 16 label table entries. Label value 8'h00 matches like any other value.
- R2: With configuration bit 0 clear, a word is stored whatever its label.
- R3: With configuration bit 1 (decode enable) set, a word is stored only if word bit [9] equals configuration bit 2 and word bit [8] equals configuration bit 3. When both bit 0 and bit 1 are set, a word must pass both tests.
- R4: With configuration bit 4 (parity mode) set, bit [31] of the stored word is 0 if the received word has an odd number of ones and 1 if it has an even number. With bit 4 clear, all 32 bits are stored unchanged.
- R5: The buffer holds 4 words and returns them oldest first. A word accepted while the buffer is full and not being read overwrites the newest entry. The full flag stays set, and empty and full are never both set.
- R6: The read data output is updated in the clock after a read strobe. A read of an empty buffer returns 32'h0.
- R7: The interrupt output equals "not empty" when configuration bit 5 is 0 and "full" when it is 1.
- R8: With configuration bit 6 set, bits [7:0] of each word read out are bit-reversed. Bit 6 has no effect on label comparison.
- R9: A configuration write, a master-clear pulse or the system reset empties the buffer and clears the full flag. While configuration bit 7 (channel reset) is set, the buffer stays empty and incoming words are ignored.
- R10: The empty and full flags change in the clock after the store or read that causes the change. A store and a read in the same clock on a non-empty buffer leave the occupancy unchanged.
- R11: A word rejected by the filters changes neither the flags nor the buffer contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset: clears configuration, label table and buffer |
| word_i | input | 32 | Received word; bit [0] is the first bit received |
| eos_i | input | 1 | One-cycle strobe: word_i is complete |
| rd_i | input | 1 | Read strobe: remove the oldest word |
| rd_data_o | output | 32 | Word read, valid in the clock after rd_i |
| cfg_we_i | input | 1 | Configuration write strobe; also empties the buffer |
| cfg_wdata_i | input | 8 | Configuration word (bit meanings in R1 to R9) |
| lbl_we_i | input | 1 | Label table write strobe |
| lbl_waddr_i | input | 4 | Label table entry index |
| lbl_wdata_i | input | 8 | Label value to store |
| master_clr_i | input | 1 | Empties the buffer; keeps configuration and labels |
| empty_o | output | 1 | Buffer empty (registered) |
| full_o | output | 1 | Buffer full (registered) |
| irq_o | output | 1 | Interrupt flag, condition chosen by configuration bit 5 |

## Verification
Internal state shows at the ports quickly. A wrong occupancy count shows on empty_o or full_o in the clock after the store or read that causes it. A wrong read or write pointer shows as a word out of order or a repeated word on rd_data_o at the next read. A bad label-table entry or filter decision is subtler: it shows only when a word with the affected label arrives. It then appears as a spurious store on empty_o the next clock, or as a missing word when the buffer is drained. For this reason the tests drain the buffer after every filtered burst and compare each word and the final empty state.

// File: rtl/arwf_pkg.sv
package arwf_pkg;
  // Configuration word, MSB first as packed.
  typedef struct packed {
    logic chan_reset;    // bit 7
    logic lbl_reverse;   // bit 6
    logic flag_full_sel; // bit 5
    logic par_en;        // bit 4
    logic dec_b9;        // bit 3
    logic dec_b10;       // bit 2
    logic dec_en;        // bit 1
    logic lbl_en;        // bit 0
  } arwf_cfg_t;

  localparam int CFG_W = $bits(arwf_cfg_t);
endpackage

// File: rtl/arwf_label_cam.sv
module arwf_label_cam #(
  parameter int N_LBL = 16,
  parameter int LBL_W = 8,
  localparam int AW = (N_LBL > 1) ? $clog2(N_LBL) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [LBL_W-1:0] wdata,
  input  logic [LBL_W-1:0] probe,
  output logic             hit
);
  logic [LBL_W-1:0] tbl [N_LBL];
  logic [N_LBL-1:0] hv;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_LBL; i++) tbl[i] <= '0;
    end else if (we) begin
      tbl[waddr] <= wdata;
    end
  end

  // One comparator per entry, all compared in parallel.
  for (genvar g = 0; g < N_LBL; g++) begin : g_cmp
    assign hv[g] = (tbl[g] == probe);
  end

  assign hit = |hv;
endmodule

// File: rtl/arwf_accept.sv
module arwf_accept #(
  parameter int WORD_W = 32,
  parameter int DEC_LO = 8   // word bit 9 sits here, word bit 10 just above
) (
  input  logic [WORD_W-1:0] word,
  input  logic              lbl_hit,
  input  logic              lbl_en,
  input  logic              dec_en,
  input  logic              dec_b10,
  input  logic              dec_b9,
  input  logic              par_en,
  output logic              accept,
  output logic [WORD_W-1:0] stored
);
  logic lbl_ok, dec_ok, par_bit;

  assign lbl_ok  = !lbl_en || lbl_hit;
  assign dec_ok  = !dec_en || ((word[DEC_LO+1] == dec_b10) && (word[DEC_LO] == dec_b9));
  assign accept  = lbl_ok && dec_ok;
  // Odd number of ones -> 0, even -> 1.
  assign par_bit = par_en ? ~(^word) : word[WORD_W-1];
  assign stored  = {par_bit, word[WORD_W-2:0]};
endmodule

// File: rtl/arwf_ring.sv
module arwf_ring #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  parameter int LBL_W  = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              clr,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              rd,
  input  logic              rev,
  output logic [WORD_W-1:0] rdata,
  output logic              empty_q,
  output logic              full_q,
  output logic              empty_n,
  output logic              full_n
);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     rd_ptr, wr_ptr, waddr;
  logic [CW-1:0]     cnt, cnt_n;
  logic              is_full, do_rd, ovw, inc;
  logic [WORD_W-1:0] head, head_fmt;

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  function automatic logic [PW-1:0] ptr_prev(input logic [PW-1:0] p);
    return (p == '0) ? LAST_PTR : p - 1'b1;
  endfunction

  assign is_full = (cnt == FULL_CNT);
  assign do_rd   = rd && (cnt != '0) && !clr;
  assign ovw     = wr && is_full && !do_rd && !clr;
  assign inc     = wr && (!is_full || do_rd) && !clr;
  assign waddr   = ovw ? ptr_prev(wr_ptr) : wr_ptr;

  always_comb begin
    cnt_n = cnt;
    if (clr)               cnt_n = '0;
    else if (inc && !do_rd) cnt_n = cnt + 1'b1;
    else if (!inc && do_rd) cnt_n = cnt - 1'b1;
  end

  assign empty_n = (cnt_n == '0);
  assign full_n  = (cnt_n == FULL_CNT);

  // Storage without reset so it can map to RAM.
  always_ff @(posedge clk) begin
    if (inc || ovw) mem[waddr] <= wdata;
  end

  assign head = mem[rd_ptr];
  always_comb begin
    head_fmt = head;
    if (rev) begin
      for (int b = 0; b < LBL_W; b++) head_fmt[b] = head[LBL_W-1-b];
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      rd_ptr  <= '0;
      wr_ptr  <= '0;
      rdata   <= '0;
    end else begin
      if (do_rd) rd_ptr <= ptr_next(rd_ptr);
      if (inc)   wr_ptr <= ptr_next(wr_ptr);
      if (rd)    rdata  <= do_rd ? head_fmt : '0;
    end
    cnt     <= cnt_n;
    empty_q <= empty_n;
    full_q  <= full_n;
  end
endmodule

// File: rtl/arinc_word_filter_buf.sv
module arinc_word_filter_buf
  import arwf_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  parameter int N_LBL  = 16,
  parameter int LBL_W  = 8,
  localparam int LAW   = (N_LBL > 1) ? $clog2(N_LBL) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              eos_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rd_data_o,
  input  logic              cfg_we_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  input  logic              lbl_we_i,
  input  logic [LAW-1:0]    lbl_waddr_i,
  input  logic [LBL_W-1:0]  lbl_wdata_i,
  input  logic              master_clr_i,
  output logic              empty_o,
  output logic              full_o,
  output logic              irq_o
);
  arwf_cfg_t         cfg_q, cfg_n;
  logic              lbl_hit, accept, clr, wr, empty_n, full_n, irq_q;
  logic [WORD_W-1:0] stored;

  assign cfg_n = cfg_we_i ? arwf_cfg_t'(cfg_wdata_i) : cfg_q;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= '0;
    else     cfg_q <= cfg_n;
  end

  arwf_label_cam #(.N_LBL(N_LBL), .LBL_W(LBL_W)) u_cam (
    .clk   (clk),
    .rst   (rst),
    .we    (lbl_we_i),
    .waddr (lbl_waddr_i),
    .wdata (lbl_wdata_i),
    .probe (word_i[LBL_W-1:0]),
    .hit   (lbl_hit)
  );

  arwf_accept #(.WORD_W(WORD_W), .DEC_LO(LBL_W)) u_acc (
    .word    (word_i),
    .lbl_hit (lbl_hit),
    .lbl_en  (cfg_q.lbl_en),
    .dec_en  (cfg_q.dec_en),
    .dec_b10 (cfg_q.dec_b10),
    .dec_b9  (cfg_q.dec_b9),
    .par_en  (cfg_q.par_en),
    .accept  (accept),
    .stored  (stored)
  );

  assign clr = rst || master_clr_i || cfg_we_i || cfg_q.chan_reset;
  assign wr  = eos_i && accept;

  arwf_ring #(.WORD_W(WORD_W), .DEPTH(DEPTH), .LBL_W(LBL_W)) u_ring (
    .clk     (clk),
    .clr     (clr),
    .wr      (wr),
    .wdata   (stored),
    .rd      (rd_i),
    .rev     (cfg_q.lbl_reverse),
    .rdata   (rd_data_o),
    .empty_q (empty_o),
    .full_q  (full_o),
    .empty_n (empty_n),
    .full_n  (full_n)
  );

  always_ff @(posedge clk) begin
    if (rst) irq_q <= 1'b0;
    else     irq_q <= cfg_n.flag_full_sel ? full_n : !empty_n;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/arwf_chk.sv
module arwf_chk (
  input logic        clk,
  input logic        rst,
  input logic        eos_i,
  input logic        rd_i,
  input logic        cfg_we_i,
  input logic        master_clr_i,
  input logic [7:0]  cfg_bits,
  input logic        empty_o,
  input logic        full_o,
  input logic        irq_o,
  input logic [31:0] rd_data_o
);
  p_flags_excl_r5: assert property (@(posedge clk) disable iff (rst)
    !(empty_o && full_o));

  p_full_overwrite_r5: assert property (@(posedge clk) disable iff (rst)
    (full_o && eos_i && !rd_i && !cfg_we_i && !master_clr_i && !cfg_bits[7]) |=> full_o);

  p_empty_read_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_i && empty_o) |=> (rd_data_o == 32'h0));

  p_irq_select_r7: assert property (@(posedge clk) disable iff (rst)
    irq_o == (cfg_bits[5] ? full_o : !empty_o));

  p_clear_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_we_i || master_clr_i) |=> (empty_o && !full_o));

  p_chan_reset_r9: assert property (@(posedge clk) disable iff (rst)
    (cfg_bits[7] && !cfg_we_i) |=> empty_o);

  p_idle_stable_r10: assert property (@(posedge clk) disable iff (rst)
    (!eos_i && !rd_i && !cfg_we_i && !master_clr_i) |=> ($stable(empty_o) && $stable(full_o)));
endmodule

bind arinc_word_filter_buf arwf_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .eos_i        (eos_i),
  .rd_i         (rd_i),
  .cfg_we_i     (cfg_we_i),
  .master_clr_i (master_clr_i),
  .cfg_bits     (cfg_q),
  .empty_o      (empty_o),
  .full_o       (full_o),
  .irq_o        (irq_o),
  .rd_data_o    (rd_data_o)
);

// File: tb/sim_arinc_word_filter_buf.sv
`timescale 1ns/1ps
module sim_arinc_word_filter_buf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] word_i = '0;
  logic        eos_i = 1'b0;
  logic        rd_i = 1'b0;
  logic [31:0] rd_data_o;
  logic        cfg_we_i = 1'b0;
  logic [7:0]  cfg_wdata_i = '0;
  logic        lbl_we_i = 1'b0;
  logic [3:0]  lbl_waddr_i = '0;
  logic [7:0]  lbl_wdata_i = '0;
  logic        master_clr_i = 1'b0;
  logic        empty_o, full_o, irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  arinc_word_filter_buf u0 (
    .clk(clk), .rst(rst), .word_i(word_i), .eos_i(eos_i), .rd_i(rd_i),
    .rd_data_o(rd_data_o), .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i),
    .lbl_we_i(lbl_we_i), .lbl_waddr_i(lbl_waddr_i), .lbl_wdata_i(lbl_wdata_i),
    .master_clr_i(master_clr_i), .empty_o(empty_o), .full_o(full_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic push(input logic [31:0] w);
    word_i = w; eos_i = 1'b1; tick(); eos_i = 1'b0;
  endtask

  task automatic pop(output logic [31:0] w);
    rd_i = 1'b1; tick(); rd_i = 1'b0; w = rd_data_o;
  endtask

  task automatic wr_cfg(input logic [7:0] c);
    cfg_wdata_i = c; cfg_we_i = 1'b1; tick(); cfg_we_i = 1'b0;
  endtask

  task automatic pop_chk(input string tag, input logic [31:0] exp);
    logic [31:0] w;
    pop(w);
    chk(tag, w, exp);
  endtask

  task automatic t_reset();
    chk("R9 reset empty", {31'd0, empty_o}, 32'd1);
    chk("R9 reset full", {31'd0, full_o}, 32'd0);
    chk("R7 reset irq", {31'd0, irq_o}, 32'd0);
    pop_chk("R6 empty read zero", 32'h0);
  endtask

  task automatic t_passthrough();
    wr_cfg(8'h00);
    push(32'h1234_5678);
    chk("R10 empty drops after store", {31'd0, empty_o}, 32'd0);
    push(32'h0000_00FF);
    push(32'hDEAD_BEEF);
    pop_chk("R2 word0", 32'h1234_5678);
    pop_chk("R2 word1", 32'h0000_00FF);
    pop_chk("R2 word2", 32'hDEAD_BEEF);
    chk("R10 empty after drain", {31'd0, empty_o}, 32'd1);
  endtask

  task automatic t_overwrite();
    wr_cfg(8'h00);
    for (int i = 0; i < 4; i++) push(32'hA000_0000 + i);
    chk("R5 full after four", {31'd0, full_o}, 32'd1);
    push(32'hBBBB_0005);
    chk("R5 full stays", {31'd0, full_o}, 32'd1);
    pop_chk("R5 ovw w0", 32'hA000_0000);
    pop_chk("R5 ovw w1", 32'hA000_0001);
    pop_chk("R5 ovw w2", 32'hA000_0002);
    pop_chk("R5 ovw newest replaced", 32'hBBBB_0005);
    chk("R5 empty after drain", {31'd0, empty_o}, 32'd1);
  endtask

  task automatic t_irq();
    wr_cfg(8'h00);
    push(32'h1);
    chk("R7 irq not-empty mode", {31'd0, irq_o}, 32'd1);
    wr_cfg(8'h20);
    chk("R7 irq full mode empty", {31'd0, irq_o}, 32'd0);
    for (int i = 0; i < 3; i++) push(32'h10 + i);
    chk("R7 irq full mode at 3", {31'd0, irq_o}, 32'd0);
    push(32'h20);
    chk("R7 irq full mode at 4", {31'd0, irq_o}, 32'd1);
    wr_cfg(8'h00);
  endtask

  task automatic t_label();
    for (int i = 0; i < 16; i++) begin
      lbl_waddr_i = 4'(i);
      lbl_wdata_i = (i == 7) ? 8'h00 : 8'(8'h10 + i);
      lbl_we_i = 1'b1; tick(); lbl_we_i = 1'b0;
    end
    wr_cfg(8'h01);
    push(32'h0000_0017);
    chk("R11 reject keeps empty", {31'd0, empty_o}, 32'd1);
    chk("R1 reject label 17", {31'd0, empty_o}, 32'd1);
    push(32'h5555_5515);
    push(32'h6666_6600);
    push(32'h7777_7744);
    push(32'h8888_881F);
    pop_chk("R1 hit 15", 32'h5555_5515);
    pop_chk("R1 hit 00", 32'h6666_6600);
    pop_chk("R1 hit 1F, 44 dropped", 32'h8888_881F);
    chk("R11 buffer unchanged by rejects", {31'd0, empty_o}, 32'd1);
  endtask

  task automatic t_decode();
    wr_cfg(8'h07);
    push(32'h0000_0215);
    push(32'h0000_0115);
    push(32'h0000_0244);
    push(32'h0000_0200);
    pop_chk("R3 both pass", 32'h0000_0215);
    pop_chk("R3 label 00 both pass", 32'h0000_0200);
    chk("R3 combined rejects", {31'd0, empty_o}, 32'd1);
    wr_cfg(8'h06);
    push(32'h0000_0344);
    chk("R3 decode reject", {31'd0, empty_o}, 32'd1);
    push(32'h0000_0244);
    pop_chk("R3 decode only pass", 32'h0000_0244);
    wr_cfg(8'h0A);
    push(32'h0000_0144);
    pop_chk("R3 bit9 match", 32'h0000_0144);
  endtask

  task automatic t_parity();
    wr_cfg(8'h10);
    push(32'h0000_0001);
    push(32'h0000_0003);
    push(32'h8000_0001);
    push(32'h8000_0000);
    pop_chk("R4 odd -> 0", 32'h0000_0001);
    pop_chk("R4 even -> 1", 32'h8000_0003);
    pop_chk("R4 even keeps 1", 32'h8000_0001);
    pop_chk("R4 odd clears", 32'h0000_0000);
    wr_cfg(8'h00);
    push(32'h0000_0003);
    pop_chk("R4 disabled raw", 32'h0000_0003);
  endtask

  task automatic t_reverse();
    wr_cfg(8'h40);
    push(32'hCAFE_0001);
    pop_chk("R8 reversed read", 32'hCAFE_0080);
    wr_cfg(8'h41);
    push(32'h0000_0015);
    push(32'h0000_00A8);
    pop_chk("R8 compare in received order", 32'h0000_00A8);
    chk("R8 reversed label not matched", {31'd0, empty_o}, 32'd1);
  endtask

  task automatic t_clear();
    wr_cfg(8'h00);
    push(32'h1); push(32'h2);
    wr_cfg(8'h00);
    chk("R9 cfg write clears", {31'd0, empty_o}, 32'd1);
    pop_chk("R9 cleared read zero", 32'h0);
    push(32'h3); push(32'h4); push(32'h5); push(32'h6);
    master_clr_i = 1'b1; tick(); master_clr_i = 1'b0;
    chk("R9 master clear empty", {31'd0, empty_o}, 32'd1);
    chk("R9 master clear full", {31'd0, full_o}, 32'd0);
    wr_cfg(8'h80);
    push(32'h7);
    chk("R9 channel reset ignores", {31'd0, empty_o}, 32'd1);
    wr_cfg(8'h00);
    push(32'h8);
    pop_chk("R9 after release", 32'h8);
  endtask

  task automatic t_simul();
    logic [31:0] w;
    wr_cfg(8'h00);
    push(32'hAAAA_0001);
    push(32'hAAAA_0002);
    word_i = 32'hAAAA_0003; eos_i = 1'b1; rd_i = 1'b1;
    tick();
    eos_i = 1'b0; rd_i = 1'b0; w = rd_data_o;
    chk("R10 simul read data", w, 32'hAAAA_0001);
    chk("R10 simul not empty", {31'd0, empty_o}, 32'd0);
    chk("R10 simul not full", {31'd0, full_o}, 32'd0);
    pop_chk("R10 simul second", 32'hAAAA_0002);
    pop_chk("R10 simul third", 32'hAAAA_0003);
    chk("R10 simul occupancy two", {31'd0, empty_o}, 32'd1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    tick();
    t_reset();
    t_passthrough();
    t_overwrite();
    t_irq();
    t_label();
    t_decode();
    t_parity();
    t_reverse();
    t_clear();
    t_simul();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule